// File: doc/BRIEF.md
# Retriggerable Prescaled Watchdog Timer

This block guards a small processor core against runaway software. Core clock cycles pass through a power-of-two prescaler (divide-by-64 by default), and each prescaler tick decrements a down-counter. When the counter expires, the block emits a one-cycle reset request and sets a sticky timeout flag. It then reloads itself and keeps running with the same period.

Software keeps the core alive by pulsing a kick strobe, which the instruction decoder raises. The kick restarts the prescaler and reloads the counter from the current timeout selection. A control register holds the following fields:
- a 3-bit period selection;
- a bit that lets counting continue while the core is halted;
- a bit that blocks entry into stop mode.

The watchdog can be switched off only by a write in the very first clock cycle after reset. Counting is frozen while the core is in stop mode.

A second sticky flag records each honoured stop entry. After a restart, software reads both flags to tell a watchdog timeout apart from a wake-up from stop. Reading the flags does not clear them. Each flag is cleared by writing a one to its bit.

Top module: `wdog_core`

## Requirements
- R1: After reset the control read value is 0x1C, both flags are 0 and the reset request is low. The 0x1C value means select 001, halt-counting enable 1 and stop-entry block 1.
- R2: Control bits 6:4 select the period in clock cycles, which is 2^PRE_LOG times a tick count. The tick count is 2^(BASE_LOG+sel-1) for sel 1 to 6 and 2^(BASE_LOG+7) for sel 7. With the defaults this gives 65,536 up to 2,097,152 cycles, and 8,388,608 for sel 7.
- R3: On expiry `wdt_reset_o` is high for exactly one cycle, and flags bit 0 is set in that same cycle. The counter then reloads, so the next expiry follows one full period later.
- R4: A kick reloads both the prescaler and the counter. The next expiry comes one full period after the clock edge that sampled the kick.
- R5: A kick sampled on the same edge as an expiry does not suppress that expiry.
- R6: Writing select 000 disables the watchdog only when the write falls in the first clock cycle after reset. A later write of 000 leaves the previous select in place, while the other control bits of that write still take effect.
- R7: Every write that changes the select reloads the prescaler and the counter for the new period, including re-enabling from 000.
- R8: While `halt_i` is high, counting pauses if control bit 3 is 0 and continues if it is 1.
- R9: While `stop_i` is high, the prescaler and the counter hold their values, and they resume from where they stopped.
- R10: A `stop_enter_i` strobe sets flags bit 1 only when control bit 2 is 0. When bit 2 is 1 the strobe is ignored.
- R11: The flags stay set until a flag write with a one in their bit (bit 0 timeout, bit 1 stop). A set in the same cycle wins over a clear.
- R12: Control bits 7, 1 and 0 always read 0, and writes to them are ignored. Writing 0xFF therefore reads back as 0x7C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Reload strobe from instruction execution |
| halt_i | input | 1 | Core is in halt mode |
| stop_i | input | 1 | Core is in stop mode |
| stop_enter_i | input | 1 | Stop-entry strobe |
| ctrl_wr_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read value |
| flag_wr_i | input | 1 | Flag clear write enable |
| flag_clr_i | input | 2 | Write-one-to-clear mask (bit 0 timeout, bit 1 stop) |
| flags_o | output | 2 | Sticky flags (bit 0 timeout, bit 1 stop) |
| wdt_reset_o | output | 1 | One-cycle reset request on expiry |

## Verification
The checker watches every cycle for the following properties:
- the reset request lasts a single cycle and always comes with the timeout flag;
- no request follows a stop-mode cycle;
- a nonzero select never returns to 000 once the first cycle has passed;
- both flags hold unless they are cleared;
- the stop flag obeys the stop-entry block bit.

Only the directed scenarios can show the exact period for each select value, and that a kick or select change restarts the full period. They also show that a kick on the expiry edge still yields a request, that halt gating follows bit 3, and that stop mode freezes the count rather than restarting it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Registered state of the control and flag logic
    typedef struct packed {
        logic [2:0] sel;
        logic       halt_en;
        logic       stop_dis;
        logic       first;
        logic       to_flag;
        logic       stop_flag;
        logic       rst_pulse;
    } wdog_ctrl_t;

    // Tick count loaded into the down-counter for a select value
    function automatic int unsigned load_ticks(logic [2:0] sel, int unsigned base_log);
        int unsigned s;
        s = 32'(sel);
        if (sel == 3'd0)
            return 32'd0;
        else if (sel == 3'd7)
            return 32'd1 << (base_log + 32'd7);
        else
            return 32'd1 << (base_log + s - 32'd1);
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_LOG = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PRE_W = PRE_LOG;
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    // A tick is reported even when a reload clears the prescaler
    assign tick_o = run_i && (pre_q.cnt == PRE_LAST);

    always_comb begin
        pre_d = pre_q;
        if (clear_i)
            pre_d.cnt = '0;
        else if (run_i)
            pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int              CNT_W   = 18,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign expire_o = tick_i && (cnt_q.cnt == ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d.cnt = load_val_i;
        else if (tick_i) begin
            if (cnt_q.cnt == ONE)
                cnt_d.cnt = load_val_i;
            else
                cnt_d.cnt = cnt_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q.cnt <= RST_VAL;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic [7:0] ctrl_wdata_i,
    input  logic       expire_i,
    input  logic       stop_enter_i,
    input  logic       flag_wr_i,
    input  logic [1:0] flag_clr_i,
    output logic [2:0] sel_o,
    output logic [2:0] sel_next_o,
    output logic       sel_change_o,
    output logic       halt_en_o,
    output logic       stop_dis_o,
    output logic       first_o,
    output logic [1:0] flags_o,
    output logic       pulse_o
);
    localparam wdog_ctrl_t CTRL_RST = '{
        sel: 3'b001, halt_en: 1'b1, stop_dis: 1'b1, first: 1'b1,
        to_flag: 1'b0, stop_flag: 1'b0, rst_pulse: 1'b0
    };

    wdog_ctrl_t ctl_d, ctl_q;
    logic       sel_ok;
    logic       wdata_unused;

    assign wdata_unused = ^{ctrl_wdata_i[7], ctrl_wdata_i[1:0]};

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.first     = 1'b0;
        ctl_d.rst_pulse = expire_i;
        sel_ok = ctrl_wr_i && ((ctrl_wdata_i[6:4] != 3'b000) || ctl_q.first);
        if (ctrl_wr_i) begin
            ctl_d.halt_en  = ctrl_wdata_i[3];
            ctl_d.stop_dis = ctrl_wdata_i[2];
        end
        if (sel_ok)
            ctl_d.sel = ctrl_wdata_i[6:4];
        if (flag_wr_i && flag_clr_i[0])
            ctl_d.to_flag = 1'b0;
        if (expire_i)
            ctl_d.to_flag = 1'b1;
        if (flag_wr_i && flag_clr_i[1])
            ctl_d.stop_flag = 1'b0;
        if (stop_enter_i && !ctl_q.stop_dis)
            ctl_d.stop_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= CTRL_RST;
        else
            ctl_q <= ctl_d;
    end

    assign sel_o        = ctl_q.sel;
    assign sel_next_o   = ctl_d.sel;
    assign sel_change_o = (ctl_d.sel != ctl_q.sel);
    assign halt_en_o    = ctl_q.halt_en;
    assign stop_dis_o   = ctl_q.stop_dis;
    assign first_o      = ctl_q.first;
    assign flags_o      = {ctl_q.stop_flag, ctl_q.to_flag};
    assign pulse_o      = ctl_q.rst_pulse;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRE_LOG  = 6,
    parameter int BASE_LOG = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick_i,
    input  logic       halt_i,
    input  logic       stop_i,
    input  logic       stop_enter_i,
    input  logic       ctrl_wr_i,
    input  logic [7:0] ctrl_wdata_i,
    output logic [7:0] ctrl_rdata_o,
    input  logic       flag_wr_i,
    input  logic [1:0] flag_clr_i,
    output logic [1:0] flags_o,
    output logic       wdt_reset_o
);
    localparam int CNT_W = BASE_LOG + 8;
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(load_ticks(3'b001, BASE_LOG));

    logic [2:0]       sel_q, sel_next;
    logic             sel_change, halt_en, stop_dis, disable_window;
    logic             run, reload, tick, expire;
    logic [CNT_W-1:0] load_val;

    assign run      = (sel_q != 3'b000) && !stop_i && (!halt_i || halt_en);
    assign reload   = kick_i || sel_change;
    assign load_val = CNT_W'(load_ticks(sel_next, BASE_LOG));

    wdog_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_i    (ctrl_wr_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .expire_i     (expire),
        .stop_enter_i (stop_enter_i),
        .flag_wr_i    (flag_wr_i),
        .flag_clr_i   (flag_clr_i),
        .sel_o        (sel_q),
        .sel_next_o   (sel_next),
        .sel_change_o (sel_change),
        .halt_en_o    (halt_en),
        .stop_dis_o   (stop_dis),
        .first_o      (disable_window),
        .flags_o      (flags_o),
        .pulse_o      (wdt_reset_o)
    );

    wdog_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clear_i (reload),
        .tick_o  (tick)
    );

    wdog_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (reload),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    assign ctrl_rdata_o = {1'b0, sel_q, halt_en, stop_dis, 2'b00};
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_i,
    input logic       stop_enter_i,
    input logic       flag_wr_i,
    input logic [1:0] flag_clr_i,
    input logic [7:0] ctrl_rdata_o,
    input logic [1:0] flags_o,
    input logic       wdt_reset_o,
    input logic       disable_window
);
    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> !wdt_reset_o);

    // R3
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |-> flags_o[0]);

    // R9
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !wdt_reset_o);

    // R6
    no_late_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o[6:4] != 3'b000 && !disable_window) |=> (ctrl_rdata_o[6:4] != 3'b000));

    // R11
    timeout_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !(flag_wr_i && flag_clr_i[0])) |=> flags_o[0]);

    // R11
    stop_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[1] && !(flag_wr_i && flag_clr_i[1])) |=> flags_o[1]);

    // R10
    stop_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_enter_i && !ctrl_rdata_o[2]) |=> flags_o[1]);

    // R10
    stop_flag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_enter_i && ctrl_rdata_o[2] && !flags_o[1]) |=> !flags_o[1]);
endmodule

bind wdog_core wdog_checker u_wdog_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_i         (stop_i),
    .stop_enter_i   (stop_enter_i),
    .flag_wr_i      (flag_wr_i),
    .flag_clr_i     (flag_clr_i),
    .ctrl_rdata_o   (ctrl_rdata_o),
    .flags_o        (flags_o),
    .wdt_reset_o    (wdt_reset_o),
    .disable_window (disable_window)
);

// File: tb/test_wdog_core.sv
module test_wdog_core;
    localparam int PRE_LOG = 2;
    localparam int BASE    = 4;
    localparam int DIV     = 1 << PRE_LOG;
    localparam int P1      = DIV * (1 << BASE);

    logic       clk = 1'b0;
    logic       rst_n, kick_i, halt_i, stop_i, stop_enter_i;
    logic       ctrl_wr_i, flag_wr_i, wdt_reset_o;
    logic [7:0] ctrl_wdata_i, ctrl_rdata_o;
    logic [1:0] flag_clr_i, flags_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdog_core #(.PRE_LOG(PRE_LOG), .BASE_LOG(BASE)) i_wdog_core (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .halt_i(halt_i), .stop_i(stop_i),
        .stop_enter_i(stop_enter_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
        .ctrl_rdata_o(ctrl_rdata_o), .flag_wr_i(flag_wr_i), .flag_clr_i(flag_clr_i),
        .flags_o(flags_o), .wdt_reset_o(wdt_reset_o)
    );

    function automatic int period(int s);
        if (s == 7) return DIV * (1 << (BASE + 7));
        return DIV * (1 << (BASE + s - 1));
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic advance(int k, output int pulses);
        pulses = 0;
        for (int i = 0; i < k; i++) begin
            step();
            if (wdt_reset_o) pulses++;
        end
    endtask

    task automatic wait_pulse(int n0, int limit, output int n);
        n = n0;
        do begin
            step();
            n++;
        end while (!wdt_reset_o && n < limit);
    endtask

    task automatic do_reset(bit wr, logic [7:0] data);
        rst_n = 1'b0; kick_i = 0; halt_i = 0; stop_i = 0; stop_enter_i = 0;
        ctrl_wr_i = 0; ctrl_wdata_i = '0; flag_wr_i = 0; flag_clr_i = '0;
        repeat (3) @(negedge clk);
        ctrl_wr_i = wr; ctrl_wdata_i = data; rst_n = 1'b1;
        step();
        ctrl_wr_i = 1'b0;
    endtask

    task automatic write_ctrl(logic [7:0] data);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = data;
        step();
        ctrl_wr_i = 1'b0;
    endtask

    task automatic kick();
        kick_i = 1'b1;
        step();
        kick_i = 1'b0;
    endtask

    task automatic t_reset_and_period();
        int n, p;
        do_reset(1'b0, 8'h00);
        chk("R1 control reset value", int'(ctrl_rdata_o), 'h1C);
        chk("R1 flags after reset", int'(flags_o), 0);
        chk("R1 request low after reset", int'(wdt_reset_o), 0);
        wait_pulse(1, P1 + 8, n);
        chk("R2 sel 1 period", n, P1);
        chk("R3 timeout flag with request", int'(flags_o[0]), 1);
        advance(1, p);
        chk("R3 request lasts one cycle", int'(wdt_reset_o), 0);
        wait_pulse(1, P1 + 8, n);
        chk("R3 automatic reload period", n, P1);
    endtask

    task automatic t_select_sweep();
        int n;
        for (int s = 2; s <= 7; s++) begin
            write_ctrl({1'b0, 3'(s), 2'b11, 2'b00});
            wait_pulse(0, period(s) + 8, n);
            chk($sformatf("R2 R7 period for select %0d", s), n, period(s));
        end
    endtask

    task automatic t_kick();
        int n, p;
        do_reset(1'b0, 8'h00);
        advance(P1 / 2 - 1, p);
        kick();
        wait_pulse(0, 2 * P1, n);
        chk("R4 period restarts at kick", n, P1);
        do_reset(1'b0, 8'h00);
        advance(P1 - 3, p);
        kick();
        chk("R4 no request on kick edge", int'(wdt_reset_o), 0);
        advance(1, p);
        chk("R4 old deadline passes quietly", int'(wdt_reset_o), 0);
        wait_pulse(1, 2 * P1, n);
        chk("R4 period from late kick", n, P1);
        do_reset(1'b0, 8'h00);
        advance(P1 - 2, p);
        kick();
        chk("R5 kick on expiry edge still requests", int'(wdt_reset_o), 1);
        wait_pulse(0, 2 * P1, n);
        chk("R5 next period after collision", n, P1);
    endtask

    task automatic t_disable_window();
        int n, p;
        do_reset(1'b1, 8'h0C);
        chk("R6 first-cycle disable accepted", int'(ctrl_rdata_o), 'h0C);
        advance(3 * P1, p);
        chk("R6 disabled gives no request", p, 0);
        write_ctrl(8'h1C);
        wait_pulse(0, 2 * P1, n);
        chk("R7 re-enable reloads full period", n, P1);
        write_ctrl(8'h0C);
        chk("R6 late disable ignored", int'(ctrl_rdata_o), 'h1C);
        wait_pulse(1, 2 * P1, n);
        chk("R6 counting continues after late disable", n, P1);
    endtask

    task automatic t_halt();
        int n, p;
        do_reset(1'b0, 8'h00);
        write_ctrl(8'h14);
        kick_i = 1'b1; halt_i = 1'b1;
        step();
        kick_i = 1'b0;
        advance(3 * P1, p);
        chk("R8 halt pauses when bit 3 is 0", p, 0);
        halt_i = 1'b0;
        wait_pulse(0, 2 * P1, n);
        chk("R8 full period after halt", n, P1);
        write_ctrl(8'h1C);
        kick_i = 1'b1; halt_i = 1'b1;
        step();
        kick_i = 1'b0;
        wait_pulse(0, 2 * P1, n);
        chk("R8 counting in halt when bit 3 is 1", n, P1);
        halt_i = 1'b0;
    endtask

    task automatic t_stop();
        int n, p;
        do_reset(1'b0, 8'h00);
        kick_i = 1'b1; stop_i = 1'b1;
        step();
        kick_i = 1'b0;
        advance(3 * P1, p);
        chk("R9 stop freezes counting", p, 0);
        stop_i = 1'b0;
        wait_pulse(0, 2 * P1, n);
        chk("R9 full period after stop", n, P1);
        kick();
        advance(P1 / 2, p);
        stop_i = 1'b1;
        advance(50, p);
        chk("R9 no request during stop", p, 0);
        stop_i = 1'b0;
        wait_pulse(P1 / 2, 2 * P1, n);
        chk("R9 count resumes, not restarts", n, P1);
    endtask

    task automatic t_flags();
        int p;
        do_reset(1'b0, 8'h00);
        stop_enter_i = 1'b1;
        step();
        stop_enter_i = 1'b0;
        chk("R10 stop entry blocked by bit 2", int'(flags_o[1]), 0);
        write_ctrl(8'h18);
        stop_enter_i = 1'b1;
        step();
        stop_enter_i = 1'b0;
        chk("R10 stop entry sets flag", int'(flags_o[1]), 1);
        advance(20, p);
        chk("R11 stop flag sticky", int'(flags_o[1]), 1);
        flag_wr_i = 1'b1; flag_clr_i = 2'b10;
        step();
        flag_wr_i = 1'b0;
        chk("R11 stop flag cleared by write", int'(flags_o[1]), 0);
        do_reset(1'b0, 8'h00);
        advance(P1 - 2, p);
        flag_wr_i = 1'b1; flag_clr_i = 2'b01;
        step();
        flag_wr_i = 1'b0;
        chk("R11 set wins over clear", int'(flags_o[0]), 1);
        chk("R3 request on collision edge", int'(wdt_reset_o), 1);
        flag_wr_i = 1'b1; flag_clr_i = 2'b01;
        step();
        flag_wr_i = 1'b0;
        chk("R11 timeout flag cleared by write", int'(flags_o[0]), 0);
    endtask

    task automatic t_reserved();
        write_ctrl(8'hFF);
        chk("R12 reserved bits read zero", int'(ctrl_rdata_o), 'h7C);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_and_period();
        t_select_sweep();
        t_kick();
        t_disable_window();
        t_halt();
        t_stop();
        t_flags();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule